// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This unit repairs the 16-bit accumulator (high byte and low byte) left behind by a plain binary add, subtract or multiply, or prepares one for a divide, so that the value is valid BCD. Packed BCD holds two digits per byte. Unpacked BCD holds one digit per byte. ASCII digits are the codes 0x30 to 0x39, so their low nibble is the digit. The arithmetic that comes before the correction is done elsewhere.

The caller presents the accumulator, the carry and auxiliary-carry flags produced by that arithmetic, and a 3-bit operation code, and pulses `valid_i`. One clock later the corrected accumulator appears. With it come new carry, auxiliary-carry, zero, sign and parity flags, and `valid_o` is high for one cycle. The outputs hold their values until the next strobe. The radix used by the multiply and divide adjusts is a parameter whose default is ten.

Top module: `bcd_adjust_unit`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. When `valid_i` is low, every result output keeps its value. After reset all outputs are 0.
- R2: Op code 0 (packed fix after add). If the low nibble of AL is above 9 or AF is in, AL gains 6 and AF out is 1, otherwise AF out is 0. Then, if the original AL is above 0x99 or CF is in, AL gains 0x60 and CF out is 1, otherwise CF out is 0. Example: 0x4C becomes 0x52.
- R3: Op code 1 (packed fix after subtract). The tests are the same as in R2, but 6 and 0x60 are subtracted instead of added. Example: 0x3B becomes 0x35.
- R4: Op code 2 (unpacked fix after add). If the low nibble of AL is above 9 or AF is in, AL gains 6, AH gains 1, and CF and AF out are 1. Otherwise CF and AF out are 0. In both cases AL bits 7:4 are then cleared. Example: 0x006E becomes 0x0104.
- R5: Op code 3 (unpacked fix after subtract). The test is the same as in R4, but AL loses 6 and AH loses 1. Example: 0x00FF becomes 0xFF09. A low digit that needs no fix leaves the digit unchanged.
- R6: Op code 4 (split after multiply). The new AH is the old AL divided by the radix, and the new AL is the remainder. CF and AF out are 0. Example: 0x2D becomes 0x0405.
- R7: Op code 5 (fold before divide). The new AL is (AH × radix + AL) mod 256, and AH becomes 0. CF and AF out are 0. Example: 0x0305 becomes 0x0023.
- R8: For every op, ZF out is 1 when the new AL is 0, SF out is bit 7 of the new AL, and PF out is 1 when the new AL has an even number of set bits.
- R9: Op codes 6 and 7 pass the accumulator, CF and AF through unchanged.
- R10: Op codes 0 and 1 leave AH unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that starts a correction |
| op_i | input | 3 | Operation code (0..5, see R2-R7 and R9) |
| acc_i | input | 16 | Accumulator to correct, AH in bits 15:8 |
| cf_i | input | 1 | Carry flag from the preceding arithmetic |
| af_i | input | 1 | Auxiliary-carry flag from the preceding arithmetic |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| acc_o | output | 16 | Corrected accumulator |
| cf_o | output | 1 | New carry flag |
| af_o | output | 1 | New auxiliary-carry flag |
| zf_o | output | 1 | New zero flag |
| sf_o | output | 1 | New sign flag |
| pf_o | output | 1 | New parity flag (1 = even) |

## Verification
The bench builds the unit with the default radix of ten. This makes the worked examples for every op reachable as exact values. It also reaches the multiply-split and divide-fold results that must wrap at 256, such as an AH of 0x30 folded with an AL of 0xFF. Directed vectors force each fix path by driving an incoming CF or AF, an AL just above 0x99, and a result of zero. A long run of pseudo-random accumulators and flags across all eight op codes then checks the flag outputs against a separate integer model.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int BYTE_W = 8;
  localparam int ACC_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    OP_PACK_ADD = 3'd0,
    OP_PACK_SUB = 3'd1,
    OP_UNP_ADD  = 3'd2,
    OP_UNP_SUB  = 3'd3,
    OP_MUL_SPLIT = 3'd4,
    OP_DIV_FOLD  = 3'd5
  } adj_op_e;

  // 1 when the byte holds an even count of ones
  function automatic logic even_parity(input logic [BYTE_W-1:0] b);
    return ~(^b);
  endfunction

  // low nibble beyond a decimal digit
  function automatic logic nib_over9(input logic [3:0] n);
    return n > 4'd9;
  endfunction
endpackage

// File: rtl/bcd_packed_fix.sv
module bcd_packed_fix
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] al_i,
  input  logic              cf_i,
  input  logic              af_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] al_o,
  output logic              cf_o,
  output logic              af_o
);
  localparam logic [BYTE_W-1:0] LO_STEP = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HI_STEP = BYTE_W'(8'h60);
  localparam logic [BYTE_W-1:0] HI_LIM  = BYTE_W'(8'h99);

  logic lo_fix_w, hi_fix_w;
  logic [BYTE_W-1:0] lo_delta, hi_delta, mid;

  assign lo_fix_w = nib_over9(al_i[3:0]) || af_i;
  assign hi_fix_w = (al_i > HI_LIM) || cf_i;
  assign lo_delta = lo_fix_w ? LO_STEP : '0;
  assign hi_delta = hi_fix_w ? HI_STEP : '0;

  always_comb begin
    if (sub_i) begin
      mid  = al_i - lo_delta;
      al_o = mid - hi_delta;
    end else begin
      mid  = al_i + lo_delta;
      al_o = mid + hi_delta;
    end
  end

  assign cf_o = hi_fix_w;
  assign af_o = lo_fix_w;
endmodule

// File: rtl/bcd_unpacked_fix.sv
module bcd_unpacked_fix
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] ah_i,
  input  logic [BYTE_W-1:0] al_i,
  input  logic              af_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] ah_o,
  output logic [BYTE_W-1:0] al_o,
  output logic              fix_o
);
  logic fix_w;
  logic [BYTE_W-1:0] al_t;

  assign fix_w = nib_over9(al_i[3:0]) || af_i;

  always_comb begin
    al_t = al_i;
    ah_o = ah_i;
    if (fix_w) begin
      if (sub_i) begin
        al_t = al_i - BYTE_W'(6);
        ah_o = ah_i - BYTE_W'(1);
      end else begin
        al_t = al_i + BYTE_W'(6);
        ah_o = ah_i + BYTE_W'(1);
      end
    end
  end

  assign al_o  = {{(BYTE_W-4){1'b0}}, al_t[3:0]};
  assign fix_o = fix_w;
endmodule

// File: rtl/bcd_radix_fix.sv
module bcd_radix_fix
  import bcd_adj_pkg::*;
#(
  parameter int RADIX = 10
) (
  input  logic [BYTE_W-1:0] ah_i,
  input  logic [BYTE_W-1:0] al_i,
  input  logic              fold_i,
  output logic [BYTE_W-1:0] ah_o,
  output logic [BYTE_W-1:0] al_o
);
  localparam logic [BYTE_W-1:0] RADIX_B = BYTE_W'(RADIX);

  logic [ACC_W-1:0] folded;
  logic [BYTE_W-1:0] quot, rem;

  assign folded = ({{BYTE_W{1'b0}}, ah_i} * {{BYTE_W{1'b0}}, RADIX_B})
                + {{BYTE_W{1'b0}}, al_i};
  assign quot = al_i / RADIX_B;
  assign rem  = al_i % RADIX_B;

  assign ah_o = fold_i ? '0 : quot;
  assign al_o = fold_i ? folded[BYTE_W-1:0] : rem;
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
#(
  parameter int RADIX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             cf_i,
  input  logic             af_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] acc_o,
  output logic             cf_o,
  output logic             af_o,
  output logic             zf_o,
  output logic             sf_o,
  output logic             pf_o
);
  adj_op_e op_w;
  logic op_is_packed, op_is_unp, op_is_radix, op_is_pass;
  logic [BYTE_W-1:0] ah_in, al_in;

  assign op_w  = adj_op_e'(op_i);
  assign ah_in = acc_i[ACC_W-1:BYTE_W];
  assign al_in = acc_i[BYTE_W-1:0];
  assign op_is_packed = (op_i == OP_PACK_ADD) || (op_i == OP_PACK_SUB);
  assign op_is_unp    = (op_i == OP_UNP_ADD)  || (op_i == OP_UNP_SUB);
  assign op_is_radix  = (op_i == OP_MUL_SPLIT) || (op_i == OP_DIV_FOLD);
  assign op_is_pass   = !(op_is_packed || op_is_unp || op_is_radix);

  logic [BYTE_W-1:0] pk_al;
  logic pk_cf, pk_af;
  bcd_packed_fix u_packed (
    .al_i(al_in), .cf_i(cf_i), .af_i(af_i), .sub_i(op_i[0]),
    .al_o(pk_al), .cf_o(pk_cf), .af_o(pk_af)
  );

  logic [BYTE_W-1:0] un_ah, un_al;
  logic un_fix;
  bcd_unpacked_fix u_unpacked (
    .ah_i(ah_in), .al_i(al_in), .af_i(af_i), .sub_i(op_i[0]),
    .ah_o(un_ah), .al_o(un_al), .fix_o(un_fix)
  );

  logic [BYTE_W-1:0] rx_ah, rx_al;
  bcd_radix_fix #(.RADIX(RADIX)) u_radix (
    .ah_i(ah_in), .al_i(al_in), .fold_i(op_i[0]),
    .ah_o(rx_ah), .al_o(rx_al)
  );

  logic [BYTE_W-1:0] nx_ah, nx_al;
  logic nx_cf, nx_af;

  always_comb begin
    nx_ah = ah_in;
    nx_al = al_in;
    nx_cf = cf_i;
    nx_af = af_i;
    case (op_w)
      OP_PACK_ADD, OP_PACK_SUB: begin
        nx_al = pk_al; nx_cf = pk_cf; nx_af = pk_af;
      end
      OP_UNP_ADD, OP_UNP_SUB: begin
        nx_ah = un_ah; nx_al = un_al; nx_cf = un_fix; nx_af = un_fix;
      end
      OP_MUL_SPLIT, OP_DIV_FOLD: begin
        nx_ah = rx_ah; nx_al = rx_al; nx_cf = 1'b0; nx_af = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      acc_o   <= '0;
      cf_o    <= 1'b0;
      af_o    <= 1'b0;
      zf_o    <= 1'b0;
      sf_o    <= 1'b0;
      pf_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        acc_o <= {nx_ah, nx_al};
        cf_o  <= nx_cf;
        af_o  <= nx_af;
        zf_o  <= (nx_al == '0);
        sf_o  <= nx_al[BYTE_W-1];
        pf_o  <= even_parity(nx_al);
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && $stable(acc_o) && $stable(cf_o) && $stable(zf_o)));
  // R10
  packed_keeps_ah_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_is_packed) |=> (acc_o[ACC_W-1:BYTE_W] == $past(ah_in)));
  // R4
  unp_high_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_is_unp) |=> (acc_o[7:4] == 4'h0 && cf_o == af_o));
  // R6
  split_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_MUL_SPLIT) |=>
      (acc_o[BYTE_W-1:0] < BYTE_W'(RADIX) && !cf_o && !af_o));
  // R7
  fold_clears_ah_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_DIV_FOLD) |=>
      (acc_o[ACC_W-1:BYTE_W] == '0 && !cf_o && !af_o));
  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_is_pass) |=> (acc_o == $past(acc_i) && cf_o == $past(cf_i)));
  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (zf_o == (acc_o[BYTE_W-1:0] == '0)));
endmodule

// File: tb/bcd_adjust_unit_tb.sv
module bcd_adjust_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [15:0] acc_i = '0;
  logic cf_i = 1'b0, af_i = 1'b0;
  logic valid_o, cf_o, af_o, zf_o, sf_o, pf_o;
  logic [15:0] acc_o;

  int checks = 0;
  int errors = 0;
  int last_ax = 0, last_cf = 0, last_af = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_adjust_unit #(.RADIX(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .acc_i(acc_i),
    .cf_i(cf_i), .af_i(af_i), .valid_o(valid_o), .acc_o(acc_o), .cf_o(cf_o),
    .af_o(af_o), .zf_o(zf_o), .sf_o(sf_o), .pf_o(pf_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // integer model from the requirements
  task automatic model(input int op, input int ax, input int cf, input int af,
                       output int eax, output int ecf, output int eaf);
    int ah, al, a;
    ah = ax / 256; al = ax % 256;
    eax = ax; ecf = cf; eaf = af;
    case (op)
      0, 1: begin
        a = al; eaf = 0; ecf = 0;
        if ((al % 16) > 9 || af != 0) begin a = (op == 0) ? a + 6 : a - 6; eaf = 1; end
        if (al > 153 || cf != 0) begin a = (op == 0) ? a + 96 : a - 96; ecf = 1; end
        a = (a + 512) % 256;
        eax = ah * 256 + a;
      end
      2, 3: begin
        if ((al % 16) > 9 || af != 0) begin
          if (op == 2) begin al = (al + 6) % 256; ah = (ah + 1) % 256; end
          else begin al = (al + 250) % 256; ah = (ah + 255) % 256; end
          ecf = 1; eaf = 1;
        end else begin ecf = 0; eaf = 0; end
        eax = ah * 256 + (al % 16);
      end
      4: begin eax = (al / 10) * 256 + (al % 10); ecf = 0; eaf = 0; end
      5: begin eax = (ah * 10 + al) % 256; ecf = 0; eaf = 0; end
      default: ;
    endcase
  endtask

  task automatic apply(input int op, input int ax, input int cf, input int af,
                       input string tag);
    int eax, ecf, eaf, al, ones;
    model(op, ax, cf, af, eax, ecf, eaf);
    @(negedge clk);
    valid_i = 1'b1; op_i = 3'(op); acc_i = 16'(ax); cf_i = 1'(cf); af_i = 1'(af);
    @(negedge clk);
    valid_i = 1'b0;
    al = eax % 256;
    ones = $countones(al[7:0]);
    chk({tag, " acc"}, int'(acc_o), eax);
    chk({tag, " cf/af"}, int'({cf_o, af_o}), ecf * 2 + eaf);
    chk({"R8 zf/sf/pf ", tag}, int'({zf_o, sf_o, pf_o}),
        (al == 0 ? 4 : 0) + (al >= 128 ? 2 : 0) + (ones % 2 == 0 ? 1 : 0));
    chk({"R1 valid ", tag}, int'(valid_o), 1);
    last_ax = eax; last_cf = ecf; last_af = eaf;
  endtask

  task automatic idle_cycle(input int ax);
    @(negedge clk);
    valid_i = 1'b0; acc_i = 16'(ax); cf_i = ~cf_i; op_i = 3'd2;
    @(negedge clk);
    chk("R1 idle valid", int'(valid_o), 0);
    chk("R1 idle hold acc", int'(acc_o), last_ax);
    chk("R1 idle hold cf/af", int'({cf_o, af_o}), last_cf * 2 + last_af);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired got=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(valid_o), 0);
    chk("R1 reset acc", int'(acc_o), 0);
    chk("R1 reset flags", int'({cf_o, af_o, zf_o, sf_o, pf_o}), 0);
    rst_n = 1'b1;

    apply(0, 16'h004C, 0, 0, "R2 example");
    apply(0, 16'h129A, 0, 0, "R2 wrap to zero R10");
    apply(0, 16'h0012, 0, 1, "R2 af in");
    apply(0, 16'h0012, 1, 0, "R2 cf in");
    apply(1, 16'h003B, 0, 0, "R3 example");
    apply(1, 16'h77A0, 0, 0, "R3 high fix R10");
    apply(2, 16'h006E, 0, 0, "R4 example");
    apply(2, 16'h0033, 0, 1, "R4 af in");
    apply(2, 16'h0834, 0, 0, "R4 no fix");
    apply(3, 16'h0004, 0, 0, "R5 no fix");
    apply(3, 16'h00FF, 0, 0, "R5 borrow");
    apply(4, 16'h002D, 1, 1, "R6 example");
    apply(4, 16'h00FF, 0, 0, "R6 max");
    apply(5, 16'h0305, 1, 1, "R7 example");
    apply(5, 16'h30FF, 0, 0, "R7 wrap");
    apply(6, 16'hA5C3, 1, 0, "R9 code6");
    apply(7, 16'h0000, 0, 1, "R9 code7");
    idle_cycle(16'h1234);
    idle_cycle(16'hFFFF);

    for (int i = 0; i < 400; i++) begin
      int op, ax, cf, af;
      op = int'($urandom_range(0, 7));
      ax = int'($urandom_range(0, 65535));
      cf = int'($urandom_range(0, 1));
      af = int'($urandom_range(0, 1));
      case (op)
        0: apply(op, ax, cf, af, "R2 rand");
        1: apply(op, ax, cf, af, "R3 rand");
        2: apply(op, ax, cf, af, "R4 rand");
        3: apply(op, ax, cf, af, "R5 rand");
        4: apply(op, ax, cf, af, "R6 rand");
        5: apply(op, ax, cf, af, "R7 rand");
        default: apply(op, ax, cf, af, "R9 rand");
      endcase
      if (i % 16 == 0) idle_cycle(int'($urandom_range(0, 65535)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule